// File: doc/BRIEF.md
# Programmable Envelope Generator

This block produces a 4-bit amplitude envelope for a sound channel. A fixed divide-by-256 prescaler feeds a 16-bit period counter, and each time that counter expires the envelope takes one step. Sixteen steps make one envelope cycle. Within a cycle a 4-bit step counter runs from 0 to 15, and the level shown on the output is either the counter value or its complement.

A 4-bit shape code chooses the waveform. Its fields are: bit 3 repeat, bit 2 rising, bit 1 mirror and bit 0 freeze. These fields select one-shot ramps, sawtooths, triangles, and ramps that stop and hold a fixed level. Writing a shape through the strobe restarts the envelope at once. The prescaler, the period counter and the step counter are all cleared. The period input is read continuously.

The controller is a three-state machine:

- **ENV_IDLE**: reset state. The output is 0.
- **ENV_RAMP**: the level steps through one cycle.
- **ENV_HOLD**: the level is frozen.

The transitions are:

- **restart**: any state goes to ENV_RAMP on a shape write.
- **advance**: stays in ENV_RAMP when a step arrives and the counter is below 15.
- **wrap**: stays in ENV_RAMP at the end of a cycle when repeat=1 and freeze=0. The counter returns to 0, and the direction flips if mirror=1.
- **settle**: goes from ENV_RAMP to ENV_HOLD at the end of a cycle when repeat=0 or freeze=1.

Top module: `env_gen`

## Requirements
- R1: After reset the level output is 0 and stays 0 until the first shape write.
- R2: A shape write restarts the envelope. The output holds 15 in the next cycle when rising (bit 2) is 0, and 0 when it is 1. The shape fields are bit 3 repeat, bit 2 rising, bit 1 mirror and bit 0 freeze.
- R3: Steps occur every 256*P clock cycles, where P is the period input, counted from the shape write.
- R4: A period of 0 gives the same step interval as a period of 1.
- R5: Inside a cycle each step moves the level by exactly one in the current direction. A cycle has 16 levels, and between steps the level does not change.
- R6: With repeat=0 (shapes 0xxx), after the 16th step the level goes to 0 and stays there.
- R7: With repeat=1, mirror=0, freeze=0 (1000, 1100), the ramp repeats in the same direction as a sawtooth.
- R8: With repeat=1, mirror=1, freeze=0 (1010, 1110), the direction reverses every cycle, giving a triangle.
- R9: With repeat=1, mirror=0, freeze=1 (1001, 1101), after one ramp the final level is held: 0 for a falling ramp, 15 for a rising one.
- R10: With repeat=1, mirror=1, freeze=1 (1011, 1111), after one ramp the complement of the final level is held: 15 for a falling ramp, 0 for a rising one.
- R11: A shape write in the middle of a ramp restarts the level and the step timing from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shape_wr | input | 1 | Shape write strobe, one cycle wide |
| shape_in | input | 4 | Shape code: repeat, rising, mirror, freeze (bit 3 down to 0) |
| period_in | input | 16 | Step period in units of 256 clocks |
| level_o | output | 4 | Current envelope level |

## Verification
The level is registered, so a shape write seen at edge W shows its start level just after W. The k-th step after that write lands on edge W + 256·P·k. The bench waits exactly that many falling edges after W before it samples. For the interval checks it also samples one falling edge earlier, where the level must not yet have moved. Hold and wrap results are read a whole number of steps after the write, so every expected value falls on a sample taken midway between edges.

// File: rtl/env_pkg.sv
package env_pkg;

    typedef enum logic [1:0] {
        ENV_IDLE = 2'd0,
        ENV_RAMP = 2'd1,
        ENV_HOLD = 2'd2
    } env_st_e;

    typedef struct packed {
        logic repeat_b;
        logic rising;
        logic mirror;
        logic freeze;
    } env_shape_t;

endpackage

// File: rtl/env_prescale.sv
module env_prescale #(
    parameter int PRE_DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic pre_tick
);
    localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart || pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign pre_tick = (pre_q == PRE_LAST) && !restart;
endmodule

// File: rtl/env_period_cnt.sv
module env_period_cnt #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pre_tick,
    input  logic [PER_W-1:0] period,
    output logic             step
);
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] last_val;

    // zero period behaves as one
    always_comb begin
        if (period == '0) begin
            last_val = '0;
        end else begin
            last_val = period - 1'b1;
        end
    end

    assign step = pre_tick && (cnt_q >= last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || step) begin
            cnt_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/env_shape_fsm.sv
module env_shape_fsm #(
    parameter int LVL_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shape_wr,
    input  env_pkg::env_shape_t shape,
    input  logic                step,
    output env_pkg::env_st_e    st,
    output logic [LVL_W-1:0]    cnt,
    output logic [LVL_W-1:0]    level
);
    import env_pkg::*;

    localparam logic [LVL_W-1:0] CNT_LAST = {LVL_W{1'b1}};

    env_st_e          st_q, st_n;
    logic [LVL_W-1:0] cnt_q, cnt_n;
    logic [LVL_W-1:0] hold_q, hold_n;
    logic             inv_q, inv_n;
    logic             rep_q, rep_n;
    logic             mir_q, mir_n;
    logic             frz_q, frz_n;
    logic [LVL_W-1:0] ramp_lvl;

    assign ramp_lvl = cnt_q ^ {LVL_W{inv_q}};

    // next-state logic
    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        hold_n = hold_q;
        inv_n  = inv_q;
        rep_n  = rep_q;
        mir_n  = mir_q;
        frz_n  = frz_q;
        if (shape_wr) begin
            // restart
            st_n  = ENV_RAMP;
            cnt_n = '0;
            inv_n = ~shape.rising;
            rep_n = shape.repeat_b;
            mir_n = shape.mirror;
            frz_n = shape.freeze;
        end else begin
            unique case (st_q)
                ENV_IDLE: begin
                    st_n = ENV_IDLE;
                end
                ENV_RAMP: begin
                    if (step) begin
                        if (cnt_q != CNT_LAST) begin
                            // advance
                            cnt_n = cnt_q + 1'b1;
                        end else if (!rep_q) begin
                            // settle to silence
                            st_n   = ENV_HOLD;
                            hold_n = '0;
                        end else if (frz_q) begin
                            // settle to final or mirrored level
                            st_n   = ENV_HOLD;
                            hold_n = ramp_lvl ^ {LVL_W{mir_q}};
                        end else begin
                            // wrap
                            cnt_n = '0;
                            inv_n = inv_q ^ mir_q;
                        end
                    end
                end
                ENV_HOLD: begin
                    st_n = ENV_HOLD;
                end
                default: begin
                    st_n = ENV_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ENV_IDLE;
            cnt_q  <= '0;
            hold_q <= '0;
            inv_q  <= 1'b0;
            rep_q  <= 1'b0;
            mir_q  <= 1'b0;
            frz_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            hold_q <= hold_n;
            inv_q  <= inv_n;
            rep_q  <= rep_n;
            mir_q  <= mir_n;
            frz_q  <= frz_n;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ENV_IDLE: level = '0;
            ENV_RAMP: level = ramp_lvl;
            ENV_HOLD: level = hold_q;
            default:  level = '0;
        endcase
    end

    assign st  = st_q;
    assign cnt = cnt_q;
endmodule

// File: rtl/env_gen.sv
module env_gen #(
    parameter int PRE_DIV = 256,
    parameter int PER_W   = 16,
    parameter int LVL_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shape_wr,
    input  logic [3:0]       shape_in,
    input  logic [PER_W-1:0] period_in,
    output logic [LVL_W-1:0] level_o
);
    import env_pkg::*;

    logic             pre_tick_w;
    logic             step_w;
    env_st_e          st_w;
    logic [LVL_W-1:0] cnt_w;
    env_shape_t       shape_w;

    assign shape_w = env_shape_t'(shape_in);

    env_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (shape_wr),
        .pre_tick (pre_tick_w)
    );

    env_period_cnt #(.PER_W(PER_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (shape_wr),
        .pre_tick (pre_tick_w),
        .period   (period_in),
        .step     (step_w)
    );

    env_shape_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .shape_wr (shape_wr),
        .shape    (shape_w),
        .step     (step_w),
        .st       (st_w),
        .cnt      (cnt_w),
        .level    (level_o)
    );
endmodule

// File: rtl/env_gen_chk.sv
module env_gen_chk #(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shape_wr,
    input logic [3:0]       shape_in,
    input logic             step,
    input env_pkg::env_st_e st,
    input logic [LVL_W-1:0] cnt,
    input logic [LVL_W-1:0] level_o
);
    import env_pkg::*;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENV_IDLE) |-> (level_o == '0));

    // R2
    restart_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shape_wr |=> (level_o == ($past(shape_in[2]) ? {LVL_W{1'b0}} : {LVL_W{1'b1}})));

    // R3
    step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);

    // R5
    ramp_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENV_RAMP && step && !shape_wr && cnt != {LVL_W{1'b1}}) |=>
        ((level_o == LVL_W'($past(level_o) + 1'b1)) ||
         (level_o == LVL_W'($past(level_o) - 1'b1))));

    // R5
    ramp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENV_RAMP && !step && !shape_wr) |=> $stable(level_o));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENV_HOLD && !shape_wr) |=> $stable(level_o));
endmodule

bind env_gen env_gen_chk #(.LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shape_wr (shape_wr),
    .shape_in (shape_in),
    .step     (step_w),
    .st       (st_w),
    .cnt      (cnt_w),
    .level_o  (level_o)
);

// File: tb/env_gen_bench.sv
module env_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 256;
    localparam int NV         = 20;
    localparam int WDOG       = 190000;

    // {shape[3:0], steps[7:0], expected level[3:0]}, period 1
    localparam logic [15:0] VEC [NV] = '{
        16'h0_00_F, // R2 falling start
        16'h0_05_A, // R5
        16'h0_10_0, // R6
        16'h4_0F_F, // R5 rising top
        16'h4_10_0, // R6
        16'h4_14_0, // R6 stays
        16'h8_10_F, // R7
        16'h8_14_B, // R7
        16'hC_10_0, // R7
        16'hC_1F_F, // R7
        16'hA_10_0, // R8
        16'hA_11_1, // R8
        16'hA_20_F, // R8
        16'hE_10_F, // R8
        16'hE_12_D, // R8
        16'h9_14_0, // R9
        16'hD_14_F, // R9
        16'hB_10_F, // R10
        16'hB_14_F, // R10
        16'hF_10_0  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shape_wr = 1'b0;
    logic [3:0]  shape_in = '0;
    logic [15:0] period_in = 16'd1;
    logic [3:0]  level_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    env_gen u_env_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .shape_wr  (shape_wr),
        .shape_in  (shape_in),
        .period_in (period_in),
        .level_o   (level_o)
    );

    function automatic string req_of(input logic [3:0] s, input int n);
        if (n == 0)      return "R2";
        if (n < 16)      return "R5";
        if (!s[3])       return "R6";
        if (!s[0])       return s[1] ? "R8" : "R7";
        return s[1] ? "R10" : "R9";
    endfunction

    task automatic check(input logic [3:0] exp, input string req);
        checks++;
        if (level_o !== exp) begin
            errors++;
            $display("FAIL %s level=%0d expected=%0d", req, level_o, exp);
        end
    endtask

    // write at the next rising edge; returns at the falling edge after it
    task automatic write_shape(input logic [3:0] s);
        @(negedge clk);
        shape_in = s;
        shape_wr = 1'b1;
        @(negedge clk);
        shape_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        // R1: quiet after reset and before any write
        check(4'd0, "R1");
        wait_cyc(600);
        check(4'd0, "R1");

        // table walk
        for (int v = 0; v < NV; v++) begin
            write_shape(VEC[v][15:12]);
            wait_cyc(DIV * int'(VEC[v][11:4]));
            check(VEC[v][3:0], req_of(VEC[v][15:12], int'(VEC[v][11:4])));
        end

        // R3: period 3 gives 768-cycle steps
        period_in = 16'd3;
        write_shape(4'hC);
        wait_cyc(DIV * 3 - 1);
        check(4'd0, "R3");
        wait_cyc(1);
        check(4'd1, "R3");
        wait_cyc(DIV * 3);
        check(4'd2, "R3");

        // R4: period 0 steps like period 1
        period_in = 16'd0;
        write_shape(4'hC);
        wait_cyc(DIV - 1);
        check(4'd0, "R4");
        wait_cyc(1);
        check(4'd1, "R4");
        wait_cyc(DIV);
        check(4'd2, "R4");

        // R11: restart in the middle of a ramp
        period_in = 16'd1;
        write_shape(4'hC);
        wait_cyc(DIV * 5);
        check(4'd5, "R5");
        write_shape(4'h0);
        check(4'd15, "R11");
        wait_cyc(DIV / 2);
        write_shape(4'hC);
        check(4'd0, "R11");
        wait_cyc(DIV - 1);
        check(4'd0, "R11");
        wait_cyc(1);
        check(4'd1, "R11");

        finish_run();
    end
endmodule